// File: doc/BRIEF.md
# Drift-Compensated Nanosecond Time Counter

This block keeps a 64-bit time-of-day value in nanoseconds. It is driven from the reference clock. A 32-bit phase accumulator adds a programmable addend on every reference clock. Each time that addition wraps past 2^32, the time value moves forward by a programmed nominal period. Trimming the addend by small amounts speeds up or slows down the time base. A bypass mode drops the accumulator and adds the period on every clock.

Software reaches the block through a 32-bit register port. It can set the control word, the addend, and the two halves of the time value, and it can read the accumulator. The time value is always split across two words, so each access follows a fixed order that keeps the 64-bit value whole. Reads take the low half first, which freezes the matching high half. Writes stage the low half first and commit the whole value when the high half arrives. Neighbouring blocks see the live time on a 64-bit output.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset the control word, addend, accumulator and time value all read 0, and `time_ns` is 0.
- R2: While the enable bit (control bit 2) is 0, the time value and the accumulator hold their values, even when the addend is rewritten.
- R3: While enabled with bypass (control bit 3) clear, each clock adds the addend to the accumulator modulo 2^32. The time value grows by the period (control bits 25:16) only on clocks where that sum carries out.
- R4: While enabled with bypass set, the time value grows by the period on every clock and the accumulator holds.
- R5: A write to the low time word (address 3) only stages the value. A write to the high time word (address 4) loads {written high, staged low} into the time value at that clock edge.
- R6: A read of the low time word also captures the high half of the same instant. A later read of the high word (address 4) returns that captured half, even if the time has carried into the high half in between.
- R7: Writing the control word (address 0) with bit 5 set clears the time value, the accumulator, the captured high half and the staged low half. The period, enable, bypass, source-select and addend settings written at that time, or held before, are kept.
- R8: A new addend written at address 1 is first used on the clock after the write. The clock of the write still uses the old addend.
- R9: The time value wraps modulo 2^64.
- R10: The control word reads back the period at bits 25:16, bypass at bit 3, enable at bit 2 and source select at bits 1:0. All other bits read 0, including the clear bit 5. The addend reads at address 1, the accumulator at address 2, and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (captures the high half on low-word reads) |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| time_ns | output | 64 | Live time value in nanoseconds |

## Verification
The bench uses the default parameters: a 32-bit accumulator and a 10-bit period field. With addends of 2^31 and 3·2^30, the carries fall on cycles that can be counted exactly, so the timing of a mid-run addend change can be told apart from an immediate one. Loading the time value just below a 32-bit boundary, and just below 2^64, brings the high-half capture race and the full 64-bit wrap within a few clocks.

// File: rtl/ptp_time_counter.sv
module ptp_time_counter #(
  parameter int ACC_W = 32,
  parameter int PER_W = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [63:0] time_ns
);
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_ADD  = 3'd1;
  localparam logic [2:0] A_ACC  = 3'd2;
  localparam logic [2:0] A_LO   = 3'd3;
  localparam logic [2:0] A_HI   = 3'd4;
  localparam int PER_LSB = 16;

  logic [PER_W-1:0] per;
  logic             byp, en;
  logic [1:0]       src;
  logic [ACC_W-1:0] addend, acc;
  logic [63:0]      cnt;
  logic [31:0]      stage_lo, shadow_hi;

  wire wr_ctrl = wr_en && (addr == A_CTRL);
  wire wr_add  = wr_en && (addr == A_ADD);
  wire wr_lo   = wr_en && (addr == A_LO);
  wire wr_hi   = wr_en && (addr == A_HI);
  wire srst    = wr_ctrl && wdata[5];

  wire [ACC_W:0] acc_sum = {1'b0, acc} + {1'b0, addend};
  wire           tick    = en && (byp || acc_sum[ACC_W]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per    <= '0;
      byp    <= 1'b0;
      en     <= 1'b0;
      src    <= '0;
      addend <= '0;
    end else begin
      if (wr_ctrl) begin
        per <= wdata[PER_LSB +: PER_W];
        byp <= wdata[3];
        en  <= wdata[2];
        src <= wdata[1:0];
      end
      if (wr_add) addend <= wdata[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      acc       <= '0;
      stage_lo  <= '0;
      shadow_hi <= '0;
    end else if (srst) begin
      cnt       <= '0;
      acc       <= '0;
      stage_lo  <= '0;
      shadow_hi <= '0;
    end else begin
      if (en && !byp) acc <= acc_sum[ACC_W-1:0];
      if (wr_hi)      cnt <= {wdata, stage_lo};
      else if (tick)  cnt <= cnt + 64'(per);
      if (wr_lo)      stage_lo <= wdata;
      if (rd_en && addr == A_LO) shadow_hi <= cnt[63:32];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[PER_LSB +: PER_W] = per;
        rdata[3:0] = {byp, en, src};
      end
      A_ADD: rdata = 32'(addend);
      A_ACC: rdata = 32'(acc);
      A_LO:  rdata = cnt[31:0];
      A_HI:  rdata = shadow_hi;
      default: rdata = '0;
    endcase
  end

  assign time_ns = cnt;

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_en) |=> ($stable(cnt) && $stable(acc))); // R2
  AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !byp && !wr_en) |=> (acc == ACC_W'($past(acc) + $past(addend)))); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !byp && !wr_en) |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + 64'($past(per))))); // R3
  AST_BYPASS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && byp && !wr_en) |=> ((cnt == $past(cnt) + 64'($past(per))) && $stable(acc))); // R4
  AST_HI_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (time_ns == {$past(wdata), $past(stage_lo)})); // R5
  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (cnt == '0 && acc == '0 && shadow_hi == '0 && stage_lo == '0)); // R7
endmodule

// File: tb/ptp_time_counter_bench.sv
module ptp_time_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] time_ns;

  ptp_time_counter u_ptp_time_counter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .time_ns(time_ns));

  always #2ns clk = ~clk;

  typedef struct { bit is_time; logic [63:0] exp; string tag; } item_t;
  item_t q[$];
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  localparam logic [31:0] P8 = 32'(8) << 16;

  initial forever begin
    @(negedge clk);
    #1ns;
    while (q.size() > 0) begin
      item_t it;
      logic [63:0] act;
      it = q.pop_front();
      act = it.is_time ? time_ns : {32'b0, rdata};
      nchk++;
      if (act !== it.exp) begin
        nfail++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdc(input logic [2:0] a, input logic [31:0] e, input string tag);
    addr = a; rd_en = 1'b1;
    q.push_back('{1'b0, {32'b0, e}, tag});
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic tmc(input logic [63:0] e, input string tag);
    q.push_back('{1'b1, e, tag});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    tmc(64'h0, "R1 time");
    rdc(3'd0, 32'h0, "R1 ctrl");
    rdc(3'd1, 32'h0, "R1 addend");
    rdc(3'd2, 32'h0, "R1 acc");
    rdc(3'd3, 32'h0, "R1 lo");
    // R10 control readback and field masking
    wr(3'd0, 32'h8000_0000 | P8 | 32'h2);
    rdc(3'd0, P8 | 32'h2, "R10 ctrl");
    rdc(3'd7, 32'h0, "R10 unused");
    // R5 staged low then commit on high
    wr(3'd3, 32'h1111_0000);
    tmc(64'h0, "R5 staged only");
    wr(3'd4, 32'h0000_0002);
    tmc(64'h2_1111_0000, "R5 commit");
    // R2 disabled hold
    wr(3'd1, 32'h8000_0000);
    idle(3);
    tmc(64'h2_1111_0000, "R2 time hold");
    rdc(3'd2, 32'h0, "R2 acc hold");
    // R3 accumulator carries: 5 ticks with addend 2^31
    wr(3'd0, P8 | 32'h4);
    idle(4);
    wr(3'd0, P8);
    tmc(64'h2_1111_0010, "R3 time");
    rdc(3'd2, 32'h8000_0000, "R3 acc");
    // R8 new addend from the next clock
    wr(3'd0, P8 | 32'h4);
    wr(3'd1, 32'hC000_0000);
    wr(3'd0, P8);
    tmc(64'h2_1111_0018, "R8 time");
    rdc(3'd2, 32'hC000_0000, "R8 acc");
    // R4 bypass: 3 ticks, accumulator holds
    wr(3'd0, P8 | 32'hC);
    idle(2);
    wr(3'd0, P8);
    tmc(64'h2_1111_0030, "R4 time");
    rdc(3'd2, 32'hC000_0000, "R4 acc");
    // R6 coherent read across a carry into the high half
    wr(3'd3, 32'hFFFF_FFF8);
    wr(3'd4, 32'h5);
    wr(3'd0, P8 | 32'hC);
    rdc(3'd3, 32'hFFFF_FFF8, "R6 lo");
    rdc(3'd4, 32'h5, "R6 hi shadow");
    wr(3'd0, P8);
    tmc(64'h6_0000_0010, "R6 time");
    // R9 64-bit wrap
    wr(3'd3, 32'hFFFF_FFFC);
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd0, P8 | 32'hC);
    wr(3'd0, P8);
    tmc(64'h4, "R9 wrap");
    // R7 soft clear
    wr(3'd3, 32'h0);
    wr(3'd4, 32'h7);
    rdc(3'd3, 32'h0, "R7 pre lo");
    rdc(3'd4, 32'h7, "R7 pre hi");
    wr(3'd3, 32'h1234);
    wr(3'd0, P8 | 32'h20 | 32'h1);
    tmc(64'h0, "R7 time cleared");
    rdc(3'd4, 32'h0, "R7 shadow cleared");
    rdc(3'd2, 32'h0, "R7 acc cleared");
    rdc(3'd0, P8 | 32'h1, "R7 ctrl kept");
    rdc(3'd1, 32'hC000_0000, "R7 addend kept");
    wr(3'd4, 32'h0);
    tmc(64'h0, "R7 staged cleared");
    done = 1'b1;
    finish_run();
  end
endmodule